// File: doc/BRIEF.md
# Matrix Multiply-Accumulate Sequencer

This block is a small microcoded engine that runs short programs against a local 2048-word by 16-bit data memory. Each instruction word names a data-memory address, either directly or as an offset within a four-word block, and carries a set of control bits. Those bits load operand registers, clear, load or store a 32-bit accumulator, step the block pointer and stop the engine. Loading the third operand starts a shift-add multiply. The multiply adds the signed product of the operand difference and the third operand into the accumulator. The program counter stays put until the multiply finishes.

The host fills the instruction store and the data memory through plain write ports, and reads the data memory back. It sets the block pointer and the program page through byte registers. A write to the program-counter register starts execution, and the host then watches the run output until the program halts.

Top module: `mmac_seq_top`

## Requirements
- R1: After reset, `run` and `stall` are both low.
- R2: A host register write with `host_sel`=0 loads `host_wdata` into the 8-bit program counter and raises `run` at that clock edge. Execution begins with the instruction at {page, counter}.
- R3: When instruction bit 7 is 1 (direct mode), the data address is instruction bits 6..0 zero-extended to 11 bits, so bits 10..7 are zero.
- R4: When instruction bit 7 is 0 (indexed mode), the data address is {block pointer, instruction bits 1..0}. `host_sel`=1 writes pointer bit 8 from `host_wdata[0]`, and `host_sel`=2 writes pointer bits 7..0.
- R5: Instruction bit 14 increments the block pointer after the current instruction has used the pointer for its address.
- R6: A multiply updates the 32-bit accumulator to acc + (A − B) × C. A, B and C are taken as signed 16-bit values, and the result wraps modulo 2^32. Bit 10 loads A and bit 9 loads B.
- R7: Instruction bit 8 loads C and starts the multiply. `stall` is then high for exactly 16 cycles, and the program counter holds during that time. Loading A or B does not raise `stall`.
- R8: Bit 13 clears the accumulator. Bit 12 loads the addressed word into accumulator bits 31..16 and zeroes bits 15..0. When both bits are set, the load wins.
- R9: Bit 11 writes accumulator bits 31..16 to the addressed data word.
- R10: Bit 15 drops `run` at the edge that executes it. A program of k instructions containing m multiplies keeps `run` high for k + 16·m cycles.
- R11: `host_sel`=3 sets the 2-bit program page from `host_wdata[1:0]`. The page forms instruction-store address bits 9..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host byte-register write strobe |
| host_sel | input | 2 | Register select: 0 counter/start, 1 pointer high, 2 pointer low, 3 page |
| host_wdata | input | 8 | Host register write data |
| prog_we | input | 1 | Instruction store write strobe |
| prog_addr | input | 10 | Instruction store write address |
| prog_wdata | input | 16 | Instruction word |
| ram_we | input | 1 | Host data-memory write strobe |
| ram_addr | input | 11 | Host data-memory address |
| ram_wdata | input | 16 | Host data-memory write data |
| ram_rdata | output | 16 | Host data-memory read data (combinational) |
| run | output | 1 | Sequencer running |
| stall | output | 1 | Multiply in progress |

## Verification
Several properties are checked on every cycle:
- the multiplier turns busy after a start and stays busy until its final step;
- `stall` never shows without `run`;
- the counter holds while stalled;
- the pointer steps by one on an increment;
- a clear zeroes the accumulator;
- a halt drops `run`.

Only the bench scenarios can show that the arithmetic is correct at the signed extremes. The same holds for which address a direct or indexed field resolves to, for the pointer stepping after its own use, and for page selection. The run length of a full program, in cycles, is also a bench-only result.

// File: rtl/mmac_pkg.sv
package mmac_pkg;
   localparam int INSTR_W = 16;
   localparam int FIELD_W = 7;

   typedef struct packed {
      logic             halt;
      logic             bic_inc;
      logic             acc_clr;
      logic             acc_load;
      logic             acc_store;
      logic             load_a;
      logic             load_b;
      logic             load_c;
      logic             direct;
      logic [FIELD_W-1:0] field;
   } mmac_instr_t;

   typedef enum logic [1:0] {
      HREG_PC     = 2'd0,
      HREG_BIC_HI = 2'd1,
      HREG_BIC_LO = 2'd2,
      HREG_PAGE   = 2'd3
   } mmac_hreg_e;
endpackage

// File: rtl/mmac_prog_store.sv
module mmac_prog_store #(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/mmac_word_ram.sv
module mmac_word_ram #(
   parameter int AW = 11,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          seq_we,
   input  logic [AW-1:0] seq_addr,
   input  logic [DW-1:0] seq_wdata,
   output logic [DW-1:0] seq_rdata,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (seq_we)       mem[seq_addr]  <= seq_wdata;
      else if (host_we) mem[host_addr] <= host_wdata;
   end

   assign seq_rdata  = mem[seq_addr];
   assign host_rdata = mem[host_addr];
endmodule

// File: rtl/mmac_addr_gen.sv
module mmac_addr_gen #(
   parameter int AW      = 11,
   parameter int FIELD_W = 7,
   parameter int OFS_W   = 2,
   parameter int IDX_W   = 9
) (
   input  logic               direct,
   input  logic [FIELD_W-1:0] field,
   input  logic [IDX_W-1:0]   bic,
   output logic [AW-1:0]      addr
);
   logic [AW-1:0] direct_addr;
   logic [AW-1:0] index_addr;

   generate
      if (IDX_W + OFS_W != AW) begin : g_bad_split
         $error("block index plus offset must cover the address");
      end
      if (OFS_W > FIELD_W) begin : g_bad_ofs
         $error("offset wider than instruction field");
      end
      if (FIELD_W >= AW) begin : g_direct_full
         assign direct_addr = field[AW-1:0];
      end else begin : g_direct_ext
         assign direct_addr = {{(AW-FIELD_W){1'b0}}, field};
      end
   endgenerate

   assign index_addr = {bic, field[OFS_W-1:0]};
   assign addr       = direct ? direct_addr : index_addr;
endmodule

// File: rtl/mmac_shift_mult.sv
module mmac_shift_mult #(
   parameter int DW = 16,
   parameter int PW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW:0]   diff_i,
   input  logic [DW-1:0] mplier_i,
   output logic          busy_o,
   output logic          last_o,
   output logic [PW-1:0] product_o
);
   localparam int CW = $clog2(DW);
   localparam logic [CW-1:0] LAST_STEP = CW'(DW - 1);

   generate
      if (PW <= DW + 1) begin : g_bad_width
         $error("product width must exceed difference width");
      end
   endgenerate

   logic [PW-1:0] mcand_q, part_q, term;
   logic [DW-1:0] mplier_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_comb begin
      term      = mplier_q[0] ? mcand_q : '0;
      last_o    = busy_q && (cnt_q == LAST_STEP);
      product_o = (cnt_q == LAST_STEP) ? part_q - term : part_q + term;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         part_q   <= '0;
         mplier_q <= '0;
         cnt_q    <= '0;
         busy_q   <= 1'b0;
      end else if (start) begin
         mcand_q  <= {{(PW-DW-1){diff_i[DW]}}, diff_i};
         part_q   <= '0;
         mplier_q <= mplier_i;
         cnt_q    <= '0;
         busy_q   <= 1'b1;
      end else if (busy_q) begin
         part_q   <= product_o;
         mcand_q  <= mcand_q << 1;
         mplier_q <= mplier_q >> 1;
         cnt_q    <= cnt_q + 1'b1;
         if (last_o) busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy_o);                                   // R7
   AST_BUSY_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last_o) |=> busy_o);                     // R7
   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start) |=> !busy_o);                     // R7
endmodule

// File: rtl/mmac_seq_top.sv
module mmac_seq_top #(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 32,
   parameter int RAM_AW = 11,
   parameter int PC_W   = 8,
   parameter int PAGE_W = 2,
   parameter int OFS_W  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      host_we,
   input  logic [1:0]                host_sel,
   input  logic [7:0]                host_wdata,
   input  logic                      prog_we,
   input  logic [PC_W+PAGE_W-1:0]    prog_addr,
   input  logic [DATA_W-1:0]         prog_wdata,
   input  logic                      ram_we,
   input  logic [RAM_AW-1:0]         ram_addr,
   input  logic [DATA_W-1:0]         ram_wdata,
   output logic [DATA_W-1:0]         ram_rdata,
   output logic                      run,
   output logic                      stall
);
   import mmac_pkg::*;

   localparam int IDX_W    = RAM_AW - OFS_W;
   localparam int BIC_HI_W = IDX_W - 8;
   localparam int PROG_AW  = PC_W + PAGE_W;

   generate
      if (BIC_HI_W < 1 || BIC_HI_W > 8) begin : g_bad_bic
         $error("block index must span two host bytes");
      end
      if (PC_W != 8) begin : g_bad_pc
         $error("program counter is written as one host byte");
      end
      if (ACC_W < 2 * DATA_W) begin : g_bad_acc
         $error("accumulator narrower than two data words");
      end
   endgenerate

   logic [PC_W-1:0]   pc_q;
   logic [PAGE_W-1:0] page_q;
   logic [IDX_W-1:0]  bic_q;
   logic              run_q;
   logic [DATA_W-1:0] a_q, b_q;
   logic [ACC_W-1:0]  acc_q;

   logic [INSTR_W-1:0] instr_raw;
   mmac_instr_t        instr;
   logic [RAM_AW-1:0]  seq_addr;
   logic [DATA_W-1:0]  seq_rdata;
   logic               busy, mult_last, exec, host_pc_wr, host_bic_wr;
   logic [ACC_W-1:0]   mult_prod;

   assign instr       = mmac_instr_t'(instr_raw);
   assign exec        = run_q && !busy;
   assign host_pc_wr  = host_we && (host_sel == HREG_PC);
   assign host_bic_wr = host_we && (host_sel == HREG_BIC_HI || host_sel == HREG_BIC_LO);

   mmac_prog_store #(.AW(PROG_AW), .DW(INSTR_W)) u_prog (
      .clk   (clk),
      .we    (prog_we),
      .waddr (prog_addr),
      .wdata (prog_wdata),
      .raddr ({page_q, pc_q}),
      .rdata (instr_raw)
   );

   mmac_addr_gen #(.AW(RAM_AW), .FIELD_W(FIELD_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_addr (
      .direct (instr.direct),
      .field  (instr.field),
      .bic    (bic_q),
      .addr   (seq_addr)
   );

   mmac_word_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
      .clk        (clk),
      .seq_we     (exec && instr.acc_store),
      .seq_addr   (seq_addr),
      .seq_wdata  (acc_q[ACC_W-1 -: DATA_W]),
      .seq_rdata  (seq_rdata),
      .host_we    (ram_we),
      .host_addr  (ram_addr),
      .host_wdata (ram_wdata),
      .host_rdata (ram_rdata)
   );

   mmac_shift_mult #(.DW(DATA_W), .PW(ACC_W)) u_mult (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (exec && instr.load_c),
      .diff_i    ({a_q[DATA_W-1], a_q} - {b_q[DATA_W-1], b_q}),
      .mplier_i  (seq_rdata),
      .busy_o    (busy),
      .last_o    (mult_last),
      .product_o (mult_prod)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         page_q <= '0;
         bic_q  <= '0;
         run_q  <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
      end else begin
         if (host_we) begin
            case (mmac_hreg_e'(host_sel))
               HREG_PC:     begin pc_q <= host_wdata; run_q <= 1'b1; end
               HREG_BIC_HI: bic_q[IDX_W-1:8] <= host_wdata[BIC_HI_W-1:0];
               HREG_BIC_LO: bic_q[7:0] <= host_wdata;
               HREG_PAGE:   page_q <= host_wdata[PAGE_W-1:0];
               default:     ;
            endcase
         end else if (exec) begin
            pc_q <= pc_q + 1'b1;
            if (instr.halt)    run_q <= 1'b0;
            if (instr.bic_inc) bic_q <= bic_q + 1'b1;
         end
         if (exec && instr.load_a) a_q <= seq_rdata;
         if (exec && instr.load_b) b_q <= seq_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        acc_q <= '0;
      else if (mult_last)                acc_q <= acc_q + mult_prod;
      else if (exec && instr.acc_load)   acc_q <= {seq_rdata, {(ACC_W-DATA_W){1'b0}}};
      else if (exec && instr.acc_clr)    acc_q <= '0;
   end

   assign run   = run_q;
   assign stall = busy;

   AST_STALL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> run);                                                  // R7
   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !host_pc_wr) |=> $stable(pc_q));                       // R7
   AST_BIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && instr.bic_inc && !host_we) |=> bic_q == $past(bic_q) + 1'b1); // R5
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && instr.acc_clr && !instr.acc_load) |=> acc_q == '0);     // R8
   AST_HALT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && instr.halt && !host_pc_wr) |=> !run);                   // R10
   AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      host_pc_wr |=> run);                                             // R2
endmodule

// File: tb/tb_mmac_seq_top.sv
module tb_mmac_seq_top;
   localparam int PERIOD = 10;

   localparam logic [15:0] I_HALT  = 16'h8000;
   localparam logic [15:0] I_INC   = 16'h4000;
   localparam logic [15:0] I_CLR   = 16'h2000;
   localparam logic [15:0] I_LDACC = 16'h1000;
   localparam logic [15:0] I_STACC = 16'h0800;
   localparam logic [15:0] I_LDA   = 16'h0400;
   localparam logic [15:0] I_LDB   = 16'h0200;
   localparam logic [15:0] I_LDC   = 16'h0100;
   localparam logic [15:0] I_DIR   = 16'h0080;

   // {A, B, C, accumulator upper word before the multiply}
   localparam int NVEC = 5;
   localparam logic [63:0] VEC [NVEC] = '{
      {16'h4000, 16'h1000, 16'h0100, 16'h0001},
      {16'h1000, 16'h3000, 16'h0200, 16'h0100},
      {16'h8000, 16'h7FFF, 16'h8000, 16'h0000},
      {16'h7FFF, 16'h8000, 16'h8000, 16'h0000},
      {16'h0003, 16'h0003, 16'h1234, 16'hABCD}
   };

   logic        clk = 0;
   logic        rst_n = 0;
   logic        host_we = 0;
   logic [1:0]  host_sel = 0;
   logic [7:0]  host_wdata = 0;
   logic        prog_we = 0;
   logic [9:0]  prog_addr = 0;
   logic [15:0] prog_wdata = 0;
   logic        ram_we = 0;
   logic [10:0] ram_addr = 0;
   logic [15:0] ram_wdata = 0;
   logic [15:0] ram_rdata;
   logic        run, stall;

   int errors = 0;
   int checks = 0;

   always #(PERIOD/2) clk = ~clk;

   mmac_seq_top dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_wdata(prog_wdata), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .run(run), .stall(stall)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic prog(input logic [9:0] a, input logic [15:0] d);
      @(negedge clk); prog_we = 1; prog_addr = a; prog_wdata = d;
      @(negedge clk); prog_we = 0;
   endtask

   task automatic wram(input logic [10:0] a, input logic [15:0] d);
      @(negedge clk); ram_we = 1; ram_addr = a; ram_wdata = d;
      @(negedge clk); ram_we = 0;
   endtask

   task automatic rram(input logic [10:0] a, output logic [15:0] d);
      @(negedge clk); ram_addr = a; #1; d = ram_rdata;
   endtask

   task automatic hreg(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk); host_we = 1; host_sel = s; host_wdata = d;
      @(negedge clk); host_we = 0;
   endtask

   task automatic start(input logic [7:0] pc, output int run_cyc, output int stall_cyc);
      run_cyc = 0; stall_cyc = 0;
      @(negedge clk); host_we = 1; host_sel = 2'd0; host_wdata = pc;
      @(negedge clk); host_we = 0;
      while (run && run_cyc < 1000) begin
         run_cyc++;
         if (stall) stall_cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      int rc, sc;
      repeat (3) @(negedge clk);
      check("R1 run after reset", run, 0);
      check("R1 stall after reset", stall, 0);
      rst_n = 1;

      // main program, page 0 counter 0, direct addressing
      prog(10'h000, I_LDACC | I_DIR | 16'd3);
      prog(10'h001, I_LDA   | I_DIR | 16'd0);
      prog(10'h002, I_LDB   | I_DIR | 16'd1);
      prog(10'h003, I_LDC   | I_DIR | 16'd2);
      prog(10'h004, I_STACC | I_DIR | 16'd4);
      prog(10'h005, I_HALT);
      hreg(2'd3, 8'd0);

      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] va, vb, vc, vi;
         longint prod;
         logic [31:0] tot;
         {va, vb, vc, vi} = VEC[v];
         wram(11'd0, va); wram(11'd1, vb); wram(11'd2, vc); wram(11'd3, vi);
         prod = (longint'($signed(va)) - longint'($signed(vb))) * longint'($signed(vc));
         tot  = {vi, 16'h0000} + prod[31:0];
         start(8'h00, rc, sc);
         rram(11'd4, rd);
         check("R6 R9 multiply-accumulate result", rd, tot[31:16]);
         check("R10 run length", rc, 22);
         check("R7 stall length", sc, 16);
      end

      // R2: run rises at the start edge
      prog(10'h040, I_HALT);
      @(negedge clk); host_we = 1; host_sel = 2'd0; host_wdata = 8'h40;
      @(negedge clk); host_we = 0;
      check("R2 run after start write", run, 1);
      @(negedge clk);
      check("R10 run after halt", run, 0);

      // R8 / R3: clear, load priority, direct field at top of window
      wram(11'd5, 16'h5A5A); wram(11'd7, 16'hFFFF); wram(11'h7F, 16'h0000);
      prog(10'h020, I_CLR | I_LDACC | I_DIR | 16'd5);
      prog(10'h021, I_STACC | I_DIR | 16'd6);
      prog(10'h022, I_STACC | I_DIR | 16'h7F);
      prog(10'h023, I_CLR);
      prog(10'h024, I_STACC | I_DIR | 16'd7);
      prog(10'h025, I_HALT);
      start(8'h20, rc, sc);
      rram(11'd6, rd);    check("R8 load wins over clear", rd, 16'h5A5A);
      rram(11'h7F, rd);   check("R3 direct field 7F", rd, 16'h5A5A);
      rram(11'd7, rd);    check("R8 clear zeroes accumulator", rd, 16'h0000);
      check("R7 no stall without multiply", sc, 0);

      // R4 / R5 / R11: indexed addressing on page 1
      wram(11'h416, 16'h1234); wram(11'h417, 16'h0000); wram(11'h41B, 16'h0000);
      prog(10'h010, I_HALT);
      prog(10'h110, I_LDACC | I_INC | 16'd2);
      prog(10'h111, I_STACC | 16'd3);
      prog(10'h112, I_HALT);
      hreg(2'd1, 8'h01);
      hreg(2'd2, 8'h05);
      hreg(2'd3, 8'h01);
      start(8'h10, rc, sc);
      rram(11'h41B, rd);  check("R4 R5 R11 indexed store after increment", rd, 16'h1234);
      rram(11'h417, rd);  check("R5 increment applies after use", rd, 16'h0000);
      check("R11 run length on page 1", rc, 3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule